// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is a single comparator channel for a multi-channel event timer. A free-running 64-bit main counter is supplied from outside. The channel holds a programmed target and emits a one-cycle expiry pulse when the counter reaches that target. The channel supports one-shot and periodic operation. In periodic operation an internal 64-bit target is stepped forward by a programmed period after each expiry. A 32-bit mode compares only the low half of the counter. In one-shot 32-bit operation, the channel also produces an extra expiry at the 32-bit rollover that comes before a distant match.

Software-style writes arrive as strobes. A configuration strobe carries a 3-bit word. A comparator strobe carries one 32-bit half, and a half-select picks the upper or lower half. A global enable gates all expiries. Raising the global enable arms the channel from the current counter value. Any write made while the global enable is high re-arms it the same way. The visible comparator value and the configuration word are outputs. Interrupt routing and the register bus are not part of this block.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator value reads all ones, the configuration word reads 0, the internal period is 0, no rollover expiry is pending, and the expiry output is low.
- R2: In 64-bit one-shot mode (configuration bits 0 and 1 both clear), the expiry output pulses for one cycle in the cycle after the counter first reaches the comparator. No further pulse follows.
- R3: In 32-bit mode (configuration bit 1 set), the match point is formed from the upper half of the counter joined to the low 32 bits of the comparator. If that value is below the counter, 2^32 is added to it.
- R4: In one-shot 32-bit mode, if the match point lies beyond the next 32-bit rollover, the channel first expires when the counter reaches that rollover (the upper half plus one, with the low half zero). It expires again at the real match point.
- R5: In periodic mode (configuration bit 0 set) with a non-zero period, each expiry steps the internal target forward by the period until the target is strictly after the counter. The visible comparator is then loaded from the target, with the value truncated to 32 bits in 32-bit mode.
- R6: In periodic mode a comparator write always updates the period. It also updates the visible comparator only when the load bit (configuration bit 2) is set. The load bit reads 0 after any comparator write that is not ignored.
- R7: In 32-bit mode a write to the upper half (half-select high) changes nothing. A lower-half write replaces the whole comparator with the data zero-extended to 64 bits.
- R8: A configuration write that sets bit 1 clears the upper 32 bits of both the comparator and the period.
- R9: All "reached" and "past" decisions use the sign of the 64-bit difference, so a target just beyond a 64-bit counter rollover is not treated as already reached.
- R10: A periodic channel whose period is 0 expires once, like a one-shot, and then stays silent.
- R11: A rising global enable, or any configuration or comparator write while the global enable is high, re-arms the channel from the counter value of the following cycle.
- R12: While the global enable is low, the expiry output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| counter | input | 64 | Main counter value |
| globalEn | input | 1 | Global enable for arming and expiry |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 3 | Configuration word: bit0 periodic, bit1 32-bit mode, bit2 load |
| cmpWrEn | input | 1 | Comparator write strobe |
| cmpWrHi | input | 1 | Comparator half-select, 1 = upper half |
| cmpWrData | input | 32 | Comparator half data |
| expire | output | 1 | One-cycle expiry pulse |
| cmpValue | output | 64 | Visible comparator value |
| cfgValue | output | 3 | Current configuration word |

## Verification
The channel is run through five mode setups: 64-bit one-shot, 32-bit one-shot with a near match, 32-bit one-shot across a rollover, 64-bit periodic, and 32-bit periodic. Each setup records the counter value at the first and second expiry, which separates a plain match, a match lifted by 2^32, an extra rollover expiry, and a period step. Directed cases follow. They cover the period written while the load bit is clear or set, ignored upper-half writes, truncation when switching to 32-bit mode, a zero period, a target beyond the 64-bit rollover, re-arming on a write while enabled, and the global enable held low.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

  // configuration word, bit 2 load, bit 1 32-bit mode, bit 0 periodic
  typedef struct packed {
    logic load;
    logic mode32;
    logic periodic;
  } chan_cfg_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic arm;
    logic advance;
    logic finish;
    logic wrapDone;
  } ctrl_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CATCH = 2'd2
  } chan_state_t;

endpackage

// File: rtl/evt_cmp_dp.sv
module evt_cmp_dp
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CNT_W-1:0]    counter,
  input  logic                cfgWrEn,
  input  chan_cfg_t           cfgWrData,
  input  logic                cmpWrEn,
  input  logic                cmpWrHi,
  input  logic [CNT_W/2-1:0]  cmpWrData,
  input  ctrl_strobe_t        strobe,
  output chan_cfg_t           cfgOut,
  output logic [CNT_W-1:0]    cmpValue,
  output logic                reached,
  output logic                pastCount,
  output logic                wrapPending,
  output logic                periodNonZero
);

  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] HALF_STEP = {{(CNT_W-1){1'b0}}, 1'b1} << HALF_W;

  chan_cfg_t        cfgReg;
  logic [CNT_W-1:0] cmpReg;
  logic [CNT_W-1:0] periodReg;
  logic [CNT_W-1:0] targetReg;
  logic [CNT_W-1:0] armAtReg;
  logic             wrapFlag;

  logic [CNT_W-1:0] lowZeroExt, mergedCmp, mergedPer, newCmp, newPer;
  logic [CNT_W-1:0] splice, match32, matchPt, nextWrap, finishVal;
  logic [CNT_W-1:0] armDiff, targetDiff;
  logic             writeIgnored, wrapFirst;

  always_comb begin
    lowZeroExt   = {{HALF_W{1'b0}}, cmpWrData};
    mergedCmp    = cmpWrHi ? {cmpWrData, cmpReg[HALF_W-1:0]}
                           : {cmpReg[CNT_W-1:HALF_W], cmpWrData};
    mergedPer    = cmpWrHi ? {cmpWrData, periodReg[HALF_W-1:0]}
                           : {periodReg[CNT_W-1:HALF_W], cmpWrData};
    newCmp       = cfgReg.mode32 ? lowZeroExt : mergedCmp;
    newPer       = cfgReg.mode32 ? lowZeroExt : mergedPer;
    writeIgnored = cfgReg.mode32 && cmpWrHi;

    // arming arithmetic from the live counter
    splice    = {counter[CNT_W-1:HALF_W], cmpReg[HALF_W-1:0]};
    match32   = (splice < counter) ? splice + HALF_STEP : splice;
    matchPt   = cfgReg.mode32 ? match32 : cmpReg;
    nextWrap  = {counter[CNT_W-1:HALF_W] + HALF_W'(1), {HALF_W{1'b0}}};
    wrapFirst = cfgReg.mode32 && !cfgReg.periodic && (matchPt > nextWrap);
    finishVal = cfgReg.mode32 ? {{HALF_W{1'b0}}, targetReg[HALF_W-1:0]} : targetReg;

    // signed-difference time comparisons
    armDiff    = counter - armAtReg;
    targetDiff = counter - targetReg;
  end

  assign reached       = !armDiff[CNT_W-1];
  assign pastCount     = targetDiff[CNT_W-1];
  assign wrapPending   = wrapFlag;
  assign periodNonZero = |periodReg;
  assign cfgOut        = cfgReg;
  assign cmpValue      = cmpReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgReg    <= '0;
      cmpReg    <= '1;
      periodReg <= '0;
      targetReg <= '0;
      armAtReg  <= '0;
      wrapFlag  <= 1'b0;
    end else begin
      if (strobe.arm) begin
        targetReg <= matchPt;
        wrapFlag  <= wrapFirst;
        armAtReg  <= wrapFirst ? nextWrap : matchPt;
      end else if (strobe.wrapDone) begin
        wrapFlag <= 1'b0;
        armAtReg <= targetReg;
      end else if (strobe.advance) begin
        targetReg <= targetReg + periodReg;
      end else if (strobe.finish) begin
        armAtReg <= targetReg;
        cmpReg   <= finishVal;
      end

      if (cfgWrEn) begin
        cfgReg <= cfgWrData;
        if (cfgWrData.mode32) begin
          cmpReg    <= {{HALF_W{1'b0}}, cmpReg[HALF_W-1:0]};
          periodReg <= {{HALF_W{1'b0}}, periodReg[HALF_W-1:0]};
        end
      end else if (cmpWrEn && !writeIgnored) begin
        if (!cfgReg.periodic || cfgReg.load) cmpReg <= newCmp;
        if (cfgReg.periodic) periodReg <= newPer;
        cfgReg.load <= 1'b0;
      end
    end
  end

  // R6
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpWrEn && !cfgWrEn && !writeIgnored) |=> !cfgReg.load);

  // R7
  hi_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpWrEn && !cfgWrEn && writeIgnored && !strobe.finish) |=> $stable(cmpValue));

  // R8
  trunc_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgWrData.mode32) |=> (cmpValue[CNT_W-1:HALF_W] == '0));

  // R4
  wrap_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrapFlag) |-> (cfgReg.mode32 && !cfgReg.periodic));

endmodule

// File: rtl/evt_cmp_ctrl.sv
module evt_cmp_ctrl
  import evt_cmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         globalEn,
  input  logic         cfgWrEn,
  input  logic         cmpWrEn,
  input  logic         cfgPeriodic,
  input  logic         reached,
  input  logic         pastCount,
  input  logic         wrapPending,
  input  logic         periodNonZero,
  output ctrl_strobe_t strobe,
  output logic         expire
);

  chan_state_t state;
  logic        enPrev;
  logic        armReq;
  logic        armNow, fireNow, repeatMode;

  always_comb begin
    armNow     = globalEn && armReq;
    fireNow    = globalEn && !armNow && (state == ST_ARMED) && reached;
    repeatMode = cfgPeriodic && periodNonZero;
    strobe          = '0;
    strobe.arm      = armNow;
    strobe.wrapDone = fireNow && !repeatMode && wrapPending;
    strobe.advance  = globalEn && !armNow && (state == ST_CATCH) && !pastCount;
    strobe.finish   = globalEn && !armNow && (state == ST_CATCH) && pastCount;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      enPrev <= 1'b0;
      armReq <= 1'b0;
      expire <= 1'b0;
    end else begin
      enPrev <= globalEn;
      expire <= fireNow;
      armReq <= globalEn && (cfgWrEn || cmpWrEn || !enPrev);
      if (!globalEn) begin
        state <= ST_IDLE;
      end else if (armNow) begin
        state <= ST_ARMED;
      end else begin
        unique case (state)
          ST_ARMED: if (fireNow) begin
            if (repeatMode)       state <= ST_CATCH;
            else if (wrapPending) state <= ST_ARMED;
            else                  state <= ST_IDLE;
          end
          ST_CATCH: if (pastCount) state <= ST_ARMED;
          default:  state <= ST_IDLE;
        endcase
      end
    end
  end

  // R12
  no_fire_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !globalEn |=> !expire);

  // R2
  pulse_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ($past(state) == ST_ARMED));

  // R10
  zero_period_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fireNow && !periodNonZero && !wrapPending) |=> (state == ST_IDLE));

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   counter,
  input  logic               globalEn,
  input  logic               cfgWrEn,
  input  logic [2:0]         cfgWrData,
  input  logic               cmpWrEn,
  input  logic               cmpWrHi,
  input  logic [CNT_W/2-1:0] cmpWrData,
  output logic               expire,
  output logic [CNT_W-1:0]   cmpValue,
  output logic [2:0]         cfgValue
);

  ctrl_strobe_t strobe;
  chan_cfg_t    cfgCur;
  logic         reached, pastCount, wrapPending, periodNonZero;

  evt_cmp_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .counter      (counter),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (chan_cfg_t'(cfgWrData)),
    .cmpWrEn      (cmpWrEn),
    .cmpWrHi      (cmpWrHi),
    .cmpWrData    (cmpWrData),
    .strobe       (strobe),
    .cfgOut       (cfgCur),
    .cmpValue     (cmpValue),
    .reached      (reached),
    .pastCount    (pastCount),
    .wrapPending  (wrapPending),
    .periodNonZero(periodNonZero)
  );

  evt_cmp_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .globalEn     (globalEn),
    .cfgWrEn      (cfgWrEn),
    .cmpWrEn      (cmpWrEn),
    .cfgPeriodic  (cfgCur.periodic),
    .reached      (reached),
    .pastCount    (pastCount),
    .wrapPending  (wrapPending),
    .periodNonZero(periodNonZero),
    .strobe       (strobe),
    .expire       (expire)
  );

  assign cfgValue = cfgCur;

endmodule

// File: tb/evt_cmp_channel_tb.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb;

  localparam real CLK_PER = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] counter = '0;
  logic        globalEn = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrData = '0;
  logic        cmpWrEn = 1'b0;
  logic        cmpWrHi = 1'b0;
  logic [31:0] cmpWrData = '0;
  logic        expire;
  logic [63:0] cmpValue;
  logic [2:0]  cfgValue;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  evt_cmp_channel u_dut (
    .clk(clk), .rst_n(rst_n), .counter(counter), .globalEn(globalEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cmpWrEn(cmpWrEn),
    .cmpWrHi(cmpWrHi), .cmpWrData(cmpWrData), .expire(expire),
    .cmpValue(cmpValue), .cfgValue(cfgValue)
  );

  typedef struct packed {
    logic [2:0]  cfg;
    logic [31:0] hi;
    logic [31:0] lo;
    logic [63:0] start;
    logic [63:0] exp1;
    logic [63:0] exp2;   // 0 = no second expiry expected
    logic [63:0] expCmp;
  } vec_t;

  // mode setups: one-shot64, one-shot32 near, one-shot32 across rollover, periodic64, periodic32
  localparam vec_t VECS [5] = '{
    '{3'd0, 32'h0, 32'h100, 64'hF0,          64'h100,         64'h0,           64'h100},
    '{3'd2, 32'h0, 32'h20,  64'h5_0000_0000, 64'h5_0000_0020, 64'h0,           64'h20},
    '{3'd2, 32'h0, 32'h10,  64'h2_FFFF_FFF0, 64'h3_0000_0000, 64'h3_0000_0010, 64'h10},
    '{3'd1, 32'h0, 32'h40,  64'h30,          64'h40,          64'h80,          64'hC0},
    '{3'd3, 32'h0, 32'h20,  64'h1_0000_0000, 64'h1_0000_0020, 64'h1_0000_0040, 64'h60}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; globalEn = 1'b0; cfgWrEn = 1'b0; cmpWrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wrCfg(input logic [2:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic wrCmp(input logic hi, input logic [31:0] v);
    @(negedge clk);
    cmpWrEn = 1'b1; cmpWrHi = hi; cmpWrData = v;
    @(negedge clk);
    cmpWrEn = 1'b0;
  endtask

  // steps the counter by one per clock; returns the counter value that caused expiry
  task automatic runFire(input int maxCyc, output logic [63:0] at, output logic seen);
    seen = 1'b0; at = '0;
    for (int i = 0; i < maxCyc && !seen; i++) begin
      @(negedge clk);
      if (expire) begin seen = 1'b1; at = counter; end
      counter = counter + 64'd1;
    end
  endtask

  task automatic stepN(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      counter = counter + 64'd1;
    end
  endtask

  initial begin
    #(CLK_PER * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] at;
    logic        seen;

    // R1 reset state
    doReset();
    @(negedge clk);
    check("R1 cmp", cmpValue, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R1 cfg", {61'd0, cfgValue}, 64'd0);
    check("R1 expire", {63'd0, expire}, 64'd0);

    // table: R2 R3 R4 R5
    for (int v = 0; v < 5; v++) begin
      doReset();
      wrCfg(VECS[v].cfg | 3'b100);
      wrCmp(1'b1, VECS[v].hi);
      wrCfg(VECS[v].cfg | 3'b100);
      wrCmp(1'b0, VECS[v].lo);
      @(negedge clk);
      counter = VECS[v].start;
      globalEn = 1'b1;
      runFire(300, at, seen);
      check($sformatf("R2/R3/R4 vec%0d first seen", v), {63'd0, seen}, 64'd1);
      check($sformatf("R2/R3/R4 vec%0d first at", v), at, VECS[v].exp1);
      if (VECS[v].exp2 == 64'd0) begin
        runFire(64, at, seen);
        check($sformatf("R2 vec%0d no second", v), {63'd0, seen}, 64'd0);
      end else begin
        runFire(300, at, seen);
        check($sformatf("R4/R5 vec%0d second at", v), at, VECS[v].exp2);
        stepN(4);
      end
      check($sformatf("R5 vec%0d visible cmp", v), cmpValue, VECS[v].expCmp);
    end

    // R6 load bit behaviour in periodic mode
    doReset();
    wrCfg(3'b001);
    wrCmp(1'b0, 32'h55);
    check("R6 no load keeps cmp", cmpValue, 64'hFFFF_FFFF_FFFF_FFFF);
    wrCfg(3'b101);
    check("R6 load bit set", {61'd0, cfgValue}, 64'd5);
    wrCmp(1'b0, 32'h66);
    check("R6 load updates cmp", cmpValue, 64'hFFFF_FFFF_0000_0066);
    check("R6 load bit cleared", {61'd0, cfgValue}, 64'd1);

    // R7 R8 32-bit writes
    doReset();
    wrCfg(3'b010);
    check("R8 truncate cmp", cmpValue, 64'h0000_0000_FFFF_FFFF);
    wrCmp(1'b1, 32'h1234);
    check("R7 upper ignored", cmpValue, 64'h0000_0000_FFFF_FFFF);
    wrCmp(1'b0, 32'h77);
    check("R7 lower zero-ext", cmpValue, 64'h77);

    // R8 period truncated on mode switch
    doReset();
    wrCfg(3'b101);
    wrCmp(1'b1, 32'h1);
    wrCfg(3'b101);
    wrCmp(1'b0, 32'h20);
    check("R8 full cmp", cmpValue, 64'h1_0000_0020);
    wrCfg(3'b011);
    check("R8 cmp truncated", cmpValue, 64'h20);
    @(negedge clk);
    counter = 64'h7_0000_0000;
    globalEn = 1'b1;
    runFire(300, at, seen);
    check("R8 first at", at, 64'h7_0000_0020);
    runFire(300, at, seen);
    check("R8 truncated period step", at, 64'h7_0000_0040);

    // R10 zero period
    doReset();
    wrCfg(3'b000);
    wrCmp(1'b1, 32'h0);
    wrCmp(1'b0, 32'h50);
    wrCfg(3'b001);
    @(negedge clk);
    counter = 64'h40;
    globalEn = 1'b1;
    runFire(300, at, seen);
    check("R10 fires once at", at, 64'h50);
    runFire(100, at, seen);
    check("R10 no repeat", {63'd0, seen}, 64'd0);
    check("R10 cmp kept", cmpValue, 64'h50);

    // R9 target beyond 64-bit rollover
    doReset();
    wrCfg(3'b000);
    wrCmp(1'b1, 32'h0);
    wrCmp(1'b0, 32'h10);
    @(negedge clk);
    counter = 64'hFFFF_FFFF_FFFF_FFF8;
    globalEn = 1'b1;
    runFire(300, at, seen);
    check("R9 fires after rollover", at, 64'h10);

    // R11 re-arm on write while enabled
    doReset();
    wrCfg(3'b000);
    wrCmp(1'b1, 32'h0);
    wrCmp(1'b0, 32'h1000);
    @(negedge clk);
    counter = 64'h100;
    globalEn = 1'b1;
    runFire(5, at, seen);
    check("R11 no early fire", {63'd0, seen}, 64'd0);
    wrCmp(1'b0, 32'h120);
    runFire(300, at, seen);
    check("R11 re-armed match", at, 64'h120);

    // R12 disabled: counter crosses target without expiry
    doReset();
    wrCfg(3'b000);
    wrCmp(1'b1, 32'h0);
    wrCmp(1'b0, 32'h30);
    @(negedge clk);
    counter = 64'h20;
    runFire(40, at, seen);
    check("R12 silent when disabled", {63'd0, seen}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule